// File: doc/BRIEF.md
# Region Page-Table Walker

This unit resolves a translation-buffer miss by locating the page-table entry for a virtual page and fetching it through a one-request-at-a-time memory port. The virtual address space is split by its top two bits into two per-process regions, a system region and a reserved quarter. Each usable region has its own table, described by a base register and a length register.

The system table is addressed physically, so a system-region miss costs one read. The two process tables live in system virtual space. For a process-region miss the unit first forms the virtual address of the wanted entry. It then reads the system entry that maps the page holding that entry. Only then does it read the process entry itself at the physical address that results. Faults found before or between the reads end the walk early with a code and a flag that says whether the page-table page itself was at fault.

The caller presents the virtual page number, with the byte offset removed, together with a start pulse. It then waits for a one-cycle done pulse that carries the entry and the fault status.

Top module: `pt_walker`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, mem_req_o and done_o are 0, fault_o is 0 and pte_o is 0.
- R2: The top two bits of the virtual page select the region: 0 first process region, 1 second process region, 2 system region, 3 reserved. A reserved-region walk ends with fault_o = 1 (access), fault_pt_o = 0, pte_o = 0 and no memory request.
- R3: If the page number (the low VA_W-2-OFS_W bits of vpage_i) is greater than or equal to the selected region's length register, the walk ends with fault_o = 2 (length), fault_pt_o = 0, pte_o = 0 and no memory request.
- R4: A system-region walk makes one read at the system base plus 4 times the page number, truncated to the physical width. It returns that word on pte_o.
- R5: For a process region the entry's system virtual address is the region base plus 4 times the page number, modulo 2^VA_W. If its top two bits are not 2, the walk ends with fault 1 and fault_pt_o = 1. If its page field is not below the system length, the walk ends with fault 2 and fault_pt_o = 1. In both cases no request is made and pte_o is 0.
- R6: Otherwise the first read is at the system base plus 4 times that address's page field. If bit 31 (valid) of the word read is 0, the walk ends after that single read with fault_o = 3 (not valid), fault_pt_o = 1, and that word on pte_o.
- R7: When that system entry is valid, the second read goes to its frame number (bits PFN_W-1:0) concatenated with the low OFS_W bits of the entry's virtual address. The word read is returned on pte_o.
- R8: If the finally returned entry has bit 31 clear, fault_o = 3 with fault_pt_o = 0. If it is set, fault_o = 0.
- R9: At most one request is outstanding. mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i, and a walk issues exactly the reads listed above.
- R10: busy_o rises the cycle after an accepted start_i and stays high through the done cycle. A start_i while busy_o is high is ignored.
- R11: done_o is a one-cycle pulse that comes with valid pte_o, fault_o and fault_pt_o. The next cycle busy_o is 0.
- R12: A write with cfg_we_i = 1 loads cfg_data_i into the length register (cfg_len_i = 1) or the base register (cfg_len_i = 0) of region cfg_rgn_i. Walks started afterwards use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table register write strobe |
| cfg_rgn_i | input | 2 | Region whose register is written |
| cfg_len_i | input | 1 | 1 writes the length register, 0 the base register |
| cfg_data_i | input | VA_W | Write data |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vpage_i | input | VA_W-OFS_W | Region and page number of the missing address |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | PFN_W+OFS_W | Physical byte address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | PTE_W | Read data (entry word) |
| done_o | output | 1 | Result pulse |
| pte_o | output | PTE_W | Last entry read in the walk, 0 if none |
| fault_o | output | 2 | 0 none, 1 access, 2 length, 3 not valid |
| fault_pt_o | output | 1 | Fault concerns the page-table page |

## Verification
The bench builds the walker with VA_W = 12, OFS_W = 4 and PFN_W = 6. That gives 64 pages per region, 16-byte pages and a 1 KiB physical space. Every page number of every region can therefore be walked under each table setting. Two settings are swept. The first has short system and first-region tables, so nested walks fall on both sides of the system length. The second has a system base near the top of physical space, so entry addresses wrap, and process bases whose entries land outside the system region. The memory model answers with a latency that depends on the address and holds a computed word pattern with periodic invalid entries. This reaches the invalid system-entry path, the invalid final-entry path and the two-read path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned NUM_RGN = 3;

  localparam logic [1:0] RGN_P0  = 2'd0;
  localparam logic [1:0] RGN_P1  = 2'd1;
  localparam logic [1:0] RGN_SYS = 2'd2;
  localparam logic [1:0] RGN_RSV = 2'd3;

  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_ACCESS = 2'd1;
  localparam logic [1:0] FLT_LENGTH = 2'd2;
  localparam logic [1:0] FLT_TNV    = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH_SYS,
    ST_FETCH_PROC,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_regs.sv
module ptw_regs import ptw_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 22
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [1:0]                       rgn_i,
  input  logic                             sel_len_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_RGN-1:0][DATA_W-1:0]   base_o,
  output logic [NUM_RGN-1:0][LEN_W-1:0]    len_o
);
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic wr;
    assign wr = we_i && (rgn_i == 2'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        len_o[g]  <= '0;
      end else if (wr) begin
        if (sel_len_i) len_o[g]  <= LEN_W'(data_i);
        else           base_o[g] <= data_i;
      end
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen import ptw_pkg::*; #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFS_W = 9,
  parameter int unsigned PA_W  = 30,
  localparam int unsigned VPN_W = VA_W - 2 - OFS_W,
  localparam int unsigned LEN_W = VPN_W + 1,
  localparam int unsigned VPG_W = VA_W - OFS_W
) (
  input  logic [VPG_W-1:0]                vpage_i,
  input  logic [NUM_RGN-1:0][VA_W-1:0]    base_i,
  input  logic [NUM_RGN-1:0][LEN_W-1:0]   len_i,
  output logic                            rsv_o,
  output logic                            sys_o,
  output logic                            len_ok_o,
  output logic                            pt_rgn_ok_o,
  output logic                            pt_len_ok_o,
  output logic [PA_W-1:0]                 sys_addr_o,
  output logic [OFS_W-1:0]                pt_ofs_o
);
  logic [1:0]       rgn;
  logic [VPN_W-1:0] vpn;
  logic [VPN_W-1:0] svpn;
  logic [VPN_W-1:0] idx;
  logic [LEN_W-1:0] lim;
  logic [VA_W-1:0]  pt_va;

  assign rgn = vpage_i[VPG_W-1 -: 2];
  assign vpn = vpage_i[VPN_W-1:0];

  always_comb begin
    unique case (rgn)
      RGN_P0:  lim = len_i[0];
      RGN_P1:  lim = len_i[1];
      default: lim = len_i[2];
    endcase
  end

  assign rsv_o    = (rgn == RGN_RSV);
  assign sys_o    = (rgn == RGN_SYS);
  assign len_ok_o = LEN_W'(vpn) < lim;

  // process entry lives in system virtual space
  assign pt_va       = base_i[rgn[0]] + VA_W'({vpn, 2'b00});
  assign svpn        = pt_va[OFS_W +: VPN_W];
  assign pt_rgn_ok_o = (pt_va[VA_W-1 -: 2] == RGN_SYS);
  assign pt_len_ok_o = LEN_W'(svpn) < len_i[2];
  assign pt_ofs_o    = pt_va[OFS_W-1:0];

  // one system-table adder serves both walk kinds
  assign idx        = sys_o ? vpn : svpn;
  assign sys_addr_o = PA_W'(base_i[2] + VA_W'({idx, 2'b00}));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; #(
  parameter int unsigned VPG_W = 23,
  parameter int unsigned OFS_W = 9,
  parameter int unsigned PFN_W = 21,
  parameter int unsigned PTE_W = 32,
  localparam int unsigned PA_W = PFN_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VPG_W-1:0]  vpage_i,
  output logic [VPG_W-1:0]  vpage_o,
  input  logic              rsv_i,
  input  logic              sys_i,
  input  logic              len_ok_i,
  input  logic              pt_rgn_ok_i,
  input  logic              pt_len_ok_i,
  input  logic [PA_W-1:0]   sys_addr_i,
  input  logic [OFS_W-1:0]  pt_ofs_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic [PTE_W-1:0]  pte_o,
  output logic [1:0]        fault_o,
  output logic              fault_pt_o
);
  walk_st_e         st_q;
  logic [VPG_W-1:0] vpage_q;
  logic             nested_q;
  logic [PA_W-1:0]  addr_q;
  logic [OFS_W-1:0] ofs_q;
  logic [PTE_W-1:0] pte_q;
  logic [1:0]       flt_q;
  logic             fpt_q;
  logic             rd_valid;

  assign rd_valid = mem_rdata_i[PTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      vpage_q  <= '0;
      nested_q <= 1'b0;
      addr_q   <= '0;
      ofs_q    <= '0;
      pte_q    <= '0;
      flt_q    <= FLT_NONE;
      fpt_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            vpage_q <= vpage_i;
            st_q    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          pte_q <= '0;
          fpt_q <= 1'b0;
          flt_q <= FLT_NONE;
          if (rsv_i) begin
            flt_q <= FLT_ACCESS;
            st_q  <= ST_DONE;
          end else if (!len_ok_i) begin
            flt_q <= FLT_LENGTH;
            st_q  <= ST_DONE;
          end else if (sys_i) begin
            addr_q   <= sys_addr_i;
            nested_q <= 1'b0;
            st_q     <= ST_FETCH_SYS;
          end else if (!pt_rgn_ok_i) begin
            flt_q <= FLT_ACCESS;
            fpt_q <= 1'b1;
            st_q  <= ST_DONE;
          end else if (!pt_len_ok_i) begin
            flt_q <= FLT_LENGTH;
            fpt_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            addr_q   <= sys_addr_i;
            ofs_q    <= pt_ofs_i;
            nested_q <= 1'b1;
            st_q     <= ST_FETCH_SYS;
          end
        end
        ST_FETCH_SYS: begin
          if (mem_rvalid_i) begin
            pte_q <= mem_rdata_i;
            if (!nested_q) begin
              flt_q <= rd_valid ? FLT_NONE : FLT_TNV;
              st_q  <= ST_DONE;
            end else if (rd_valid) begin
              addr_q <= {mem_rdata_i[PFN_W-1:0], ofs_q};
              st_q   <= ST_FETCH_PROC;
            end else begin
              flt_q <= FLT_TNV;
              fpt_q <= 1'b1;
              st_q  <= ST_DONE;
            end
          end
        end
        ST_FETCH_PROC: begin
          if (mem_rvalid_i) begin
            pte_q <= mem_rdata_i;
            flt_q <= rd_valid ? FLT_NONE : FLT_TNV;
            st_q  <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vpage_o    = vpage_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_FETCH_SYS) || (st_q == ST_FETCH_PROC);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_DONE);
  assign pte_o      = pte_q;
  assign fault_o    = flt_q;
  assign fault_pt_o = fpt_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFS_W = 9,
  parameter int unsigned PFN_W = 21,
  parameter int unsigned PTE_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_rgn_i,
  input  logic                     cfg_len_i,
  input  logic [VA_W-1:0]          cfg_data_i,
  input  logic                     start_i,
  input  logic [VA_W-OFS_W-1:0]    vpage_i,
  output logic                     busy_o,
  output logic                     mem_req_o,
  output logic [PFN_W+OFS_W-1:0]   mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i,
  output logic                     done_o,
  output logic [PTE_W-1:0]         pte_o,
  output logic [1:0]               fault_o,
  output logic                     fault_pt_o
);
  localparam int unsigned VPN_W = VA_W - 2 - OFS_W;
  localparam int unsigned LEN_W = VPN_W + 1;
  localparam int unsigned VPG_W = VA_W - OFS_W;
  localparam int unsigned PA_W  = PFN_W + OFS_W;

  logic [NUM_RGN-1:0][VA_W-1:0]  base;
  logic [NUM_RGN-1:0][LEN_W-1:0] len;
  logic [VPG_W-1:0]              vpage_q;
  logic                          rsv, sys, len_ok, pt_rgn_ok, pt_len_ok;
  logic [PA_W-1:0]               sys_addr;
  logic [OFS_W-1:0]              pt_ofs;

  ptw_regs #(
    .DATA_W (VA_W),
    .LEN_W  (LEN_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .rgn_i     (cfg_rgn_i),
    .sel_len_i (cfg_len_i),
    .data_i    (cfg_data_i),
    .base_o    (base),
    .len_o     (len)
  );

  ptw_addr_gen #(
    .VA_W  (VA_W),
    .OFS_W (OFS_W),
    .PA_W  (PA_W)
  ) i_addr_gen (
    .vpage_i     (vpage_q),
    .base_i      (base),
    .len_i       (len),
    .rsv_o       (rsv),
    .sys_o       (sys),
    .len_ok_o    (len_ok),
    .pt_rgn_ok_o (pt_rgn_ok),
    .pt_len_ok_o (pt_len_ok),
    .sys_addr_o  (sys_addr),
    .pt_ofs_o    (pt_ofs)
  );

  ptw_ctrl #(
    .VPG_W (VPG_W),
    .OFS_W (OFS_W),
    .PFN_W (PFN_W),
    .PTE_W (PTE_W)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .vpage_i      (vpage_i),
    .vpage_o      (vpage_q),
    .rsv_i        (rsv),
    .sys_i        (sys),
    .len_ok_i     (len_ok),
    .pt_rgn_ok_i  (pt_rgn_ok),
    .pt_len_ok_i  (pt_len_ok),
    .sys_addr_i   (sys_addr),
    .pt_ofs_i     (pt_ofs),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .pte_o        (pte_o),
    .fault_o      (fault_o),
    .fault_pt_o   (fault_pt_o)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int unsigned ADDR_W = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              done_o,
  input logic [1:0]        fault_o,
  input logic              fault_pt_o
);
  logic req_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 req_seen <= 1'b0;
    else if (start_i && !busy_o) req_seen <= 1'b0;
    else if (mem_req_o)          req_seen <= 1'b1;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  req_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  // R11
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  // R5
  pt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_pt_o |-> fault_o != 2'd0);

  // R3
  early_fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (fault_o == 2'd1 || fault_o == 2'd2) |-> !req_seen);
endmodule

bind pt_walker ptw_chk #(.ADDR_W(PA_W)) i_ptw_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_pt_o   (fault_pt_o)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam int unsigned VA_W  = 12;
  localparam int unsigned OFS_W = 4;
  localparam int unsigned PFN_W = 6;
  localparam int unsigned PTE_W = 32;
  localparam int unsigned VPN_W = VA_W - 2 - OFS_W;
  localparam int unsigned PA_W  = PFN_W + OFS_W;
  localparam int unsigned VPG_W = VA_W - OFS_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_rgn_i = '0;
  logic             cfg_len_i = 1'b0;
  logic [VA_W-1:0]  cfg_data_i = '0;
  logic             start_i = 1'b0;
  logic [VPG_W-1:0] vpage_i = '0;
  logic             busy_o, mem_req_o, done_o, fault_pt_o;
  logic [PA_W-1:0]  mem_addr_o;
  logic             mem_rvalid_i = 1'b0;
  logic [PTE_W-1:0] mem_rdata_i = '0;
  logic [PTE_W-1:0] pte_o;
  logic [1:0]       fault_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [VA_W-1:0] m_base [3];
  int              m_len  [3];

  int              req_n = 0;
  logic [PA_W-1:0] log_a [2];

  always #4 clk = ~clk;

  pt_walker #(
    .VA_W (VA_W), .OFS_W (OFS_W), .PFN_W (PFN_W), .PTE_W (PTE_W)
  ) i_pt_walker (
    .clk_i (clk), .rst_ni (rst_ni),
    .cfg_we_i (cfg_we_i), .cfg_rgn_i (cfg_rgn_i), .cfg_len_i (cfg_len_i), .cfg_data_i (cfg_data_i),
    .start_i (start_i), .vpage_i (vpage_i), .busy_o (busy_o),
    .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i), .mem_rdata_i (mem_rdata_i),
    .done_o (done_o), .pte_o (pte_o), .fault_o (fault_o), .fault_pt_o (fault_pt_o)
  );

  function automatic logic [31:0] mem_word(input logic [PA_W-1:0] a);
    int w;
    w = int'(a[PA_W-1:2]);
    return {1'((w % 7) != 3), 8'(w), ~8'(w), 8'(w * 3), 1'b1, 6'(w * 5 + 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory: one request at a time, latency from address
  initial begin
    bit              pend;
    int              wcnt;
    logic [PA_W-1:0] cur;
    pend = 0; wcnt = 0; cur = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid_i) begin
        mem_rvalid_i = 1'b0;
        pend = 0;
      end
      if (!pend && mem_req_o === 1'b1) begin
        pend = 1;
        cur  = mem_addr_o;
        wcnt = int'(mem_addr_o[PA_W-1:2]) % 3;
        if (req_n < 2) log_a[req_n] = mem_addr_o;
        req_n++;
      end else if (pend && wcnt > 0) begin
        wcnt--;
      end
      if (pend && wcnt == 0 && !mem_rvalid_i) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_word(cur);
      end
    end
  end

  task automatic cfg(input int r, input bit is_len, input int val);
    cfg_we_i = 1'b1; cfg_rgn_i = 2'(r); cfg_len_i = is_len; cfg_data_i = VA_W'(val);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (is_len) m_len[r] = val;
    else        m_base[r] = VA_W'(val);
  endtask

  task automatic model(input logic [VPG_W-1:0] vp, output logic [1:0] code, output bit pt,
                       output logic [31:0] pte, output int n, output logic [PA_W-1:0] a0,
                       output logic [PA_W-1:0] a1, output string tag);
    int rgn, vpn, svpn;
    logic [VA_W-1:0] ptva;
    logic [31:0] e;
    rgn = int'(vp[VPG_W-1 -: 2]);
    vpn = int'(vp[VPN_W-1:0]);
    code = 2'd0; pt = 0; pte = '0; n = 0; a0 = '0; a1 = '0; tag = "R2";
    if (rgn == 3) begin code = 2'd1; tag = "R2"; return; end
    if (vpn >= m_len[rgn]) begin code = 2'd2; tag = "R3"; return; end
    if (rgn == 2) begin
      a0 = PA_W'(m_base[2] + VA_W'(4 * vpn));
      e = mem_word(a0); n = 1; pte = e;
      code = e[31] ? 2'd0 : 2'd3;
      tag  = e[31] ? "R4" : "R8";
      return;
    end
    ptva = m_base[rgn] + VA_W'(4 * vpn);
    if (ptva[VA_W-1 -: 2] != 2'd2) begin code = 2'd1; pt = 1; tag = "R5"; return; end
    svpn = int'(ptva[OFS_W +: VPN_W]);
    if (svpn >= m_len[2]) begin code = 2'd2; pt = 1; tag = "R5"; return; end
    a0 = PA_W'(m_base[2] + VA_W'(4 * svpn));
    e = mem_word(a0); n = 1; pte = e;
    if (!e[31]) begin code = 2'd3; pt = 1; tag = "R6"; return; end
    a1 = {e[PFN_W-1:0], ptva[OFS_W-1:0]};
    e = mem_word(a1); n = 2; pte = e;
    code = e[31] ? 2'd0 : 2'd3;
    tag  = e[31] ? "R7" : "R8";
  endtask

  task automatic walk(input logic [VPG_W-1:0] vp, input bit poke);
    logic [1:0] ec; bit ept; logic [31:0] ep; int en;
    logic [PA_W-1:0] e0, e1; string tag; int cyc;
    model(vp, ec, ept, ep, en, e0, e1, tag);
    req_n = 0;
    start_i = 1'b1; vpage_i = vp;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R10", "busy after start", 32'(busy_o), 1);
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 60) begin
      if (poke && cyc == 1) begin start_i = 1'b1; vpage_i = ~vp; end
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R11", "done within bound", 32'(cyc), 60);
    chk(fault_o === ec, tag, "fault code", 32'(fault_o), 32'(ec));
    chk(fault_pt_o === ept, tag, "table-page flag", 32'(fault_pt_o), 32'(ept));
    chk(pte_o === ep, tag, "entry", pte_o, ep);
    chk(req_n == en, poke ? "R10" : "R9", "read count", 32'(req_n), 32'(en));
    if (en > 0)
      chk(log_a[0] === e0, (vp[VPG_W-1 -: 2] == 2'd2) ? "R4" : "R6", "first read address",
          32'(log_a[0]), 32'(e0));
    if (en > 1)
      chk(log_a[1] === e1, "R7", "second read address", 32'(log_a[1]), 32'(e1));
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R11", "done pulse then idle",
        32'({done_o, busy_o}), 0);
  endtask

  task automatic sweep();
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < (1 << VPN_W); v++)
        walk({2'(r), VPN_W'(v)}, (v % 16) == 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] ec; bit ept; logic [31:0] ep; int en;
    logic [PA_W-1:0] e0, e1; string tag;
    for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_len[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0, "R1", "control outputs in reset",
        32'({busy_o, mem_req_o, done_o}), 0);
    chk(fault_o === 2'd0 && pte_o === '0, "R1", "result outputs in reset", pte_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0, "R1", "control outputs after reset",
        32'({busy_o, mem_req_o, done_o}), 0);

    // setting one: short tables, nested walks straddle the system length
    cfg(2, 0, 'h040); cfg(2, 1, 20);
    cfg(0, 0, 'h810); cfg(0, 1, 40);
    cfg(1, 0, 'h8C8); cfg(1, 1, 64);
    sweep();

    // setting two: wrapping system base, process tables outside system space
    cfg(2, 0, 'h3F0); cfg(2, 1, 64);
    cfg(0, 0, 'hFF0); cfg(0, 1, 64);
    cfg(1, 0, 'h400); cfg(1, 1, 10);
    sweep();

    // R12: a new length applies to the next walk
    cfg(1, 1, 0);
    model({2'd1, VPN_W'(0)}, ec, ept, ep, en, e0, e1, tag);
    chk(ec == 2'd2, "R12", "model length fault after rewrite", 32'(ec), 2);
    walk({2'd1, VPN_W'(0)}, 0);
    chk(fault_o === 2'd2, "R12", "fault after length rewrite", 32'(fault_o), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule